// File: doc/BRIEF.md
# Round-Robin Supervisor/Worker Thread Issue Scheduler

This block picks, on every clock cycle, which hardware thread context issues its next instruction. A fixed set of contexts shares one pipeline. A slot pointer walks through them in a fixed cyclic order and gives each context one turn per rotation. A context that holds no task still takes its turn, and that turn issues a bubble. Each context therefore sees the same issue rate whatever the other contexts are doing.

One context holds the supervisor program. While the supervisor has its turn it can ask for a new worker task, giving the entry address. The scheduler places the task in the free context with the lowest index. A worker keeps its context until its exit line is raised, and the context then returns to the free pool. If the supervisor asks for a task when no context is free, it gives up its own context to the task and becomes suspended. Its next program counter is held aside. The first worker that exits after that receives the supervisor, which continues from the held counter.

Top module: `barrel_sched`

## Requirements
- R1: No more than one context is ever in supervisor mode. `issue_sup` is high only on the turn of that context.
- R2: A spawn request is acted on only in a cycle where the issuing context is the running supervisor. In any other cycle, including every cycle while the supervisor is suspended, the request changes no context.
- R3: A worker's exit line frees its context, and that context's later turns issue bubbles until a new task is placed there. Exit lines of free contexts and of the supervisor context are ignored. A spawned task goes to the lowest-index context that is free, or that is a worker exiting in the same cycle.
- R4: A spawn while no context is free suspends the supervisor. `sup_suspended` rises after that clock edge. On its next turn the supervisor's own context runs the worker from the spawn address.
- R5: While the supervisor is suspended, the exit of a worker (the lowest-index one if several exit together) turns that worker's context into the supervisor. The supervisor continues at the counter value it had at the suspending spawn plus one, and `sup_suspended` falls.
- R6: `issue_ctx` takes the values 0, 1, …, 5, 0, … on successive cycles from reset.
- R7: Each issue from an occupied context advances that context's program counter by one. A newly placed worker issues its spawn address first.
- R8: After reset, context 0 is the supervisor at counter 0, contexts 1 to 5 are free, the slot is 0, and `sup_suspended` is low.
- R9: The turn of a free context issues a bubble, with `issue_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spawn_req | input | 1 | Supervisor asks for a new worker task |
| spawn_addr | input | 16 | Entry address of the requested task |
| exit_i | input | 6 | One exit line per context, bit i for context i |
| issue_valid | output | 1 | The current slot issues an instruction (low = bubble) |
| issue_ctx | output | 3 | Index of the context holding the current slot |
| issue_pc | output | 16 | Program counter issued in the current slot |
| issue_sup | output | 1 | The issuing context is the supervisor |
| sup_suspended | output | 1 | The supervisor has given its context to a worker |

## Verification
Every cycle is compared against a slot-by-slot model, so bubbles, counters and rotation are checked on each turn and not only at chosen points. The bench fills all five free contexts, then spawns once more to force the lending of the supervisor context. A design that placed the task anywhere else, or that kept issuing as supervisor, shows a wrong counter or a wrong `issue_sup` on context 0. A worker exit then tests resumption: restoring the wrong counter, or failing to clear the suspension, is visible on the next supervisor turn. Spawns outside the supervisor's turn, a spawn while the supervisor is suspended, and exit lines on the supervisor and on free contexts are all applied. A scheduler that honoured any of them would start issuing in a context that must stay empty, or would lose the supervisor. Exits of several contexts in one cycle and reuse of the lent context check the lowest-index rule.

// File: rtl/barrel_sched.sv
module barrel_sched #(
  parameter int NCTX = 6,
  parameter int PCW = 16,
  parameter logic [PCW-1:0] BOOT_PC = '0,
  localparam int CW = $clog2(NCTX)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            spawn_req,
  input  logic [PCW-1:0]  spawn_addr,
  input  logic [NCTX-1:0] exit_i,
  output logic            issue_valid,
  output logic [CW-1:0]   issue_ctx,
  output logic [PCW-1:0]  issue_pc,
  output logic            issue_sup,
  output logic            sup_suspended
);
  typedef enum logic [1:0] {FREE, SUPV, WORK} mode_t;
  localparam logic [CW-1:0] LAST = CW'(NCTX - 1);

  mode_t          mode_q [NCTX];
  mode_t          mode_n [NCTX];
  logic [PCW-1:0] pc_q [NCTX];
  logic [PCW-1:0] pc_n [NCTX];
  logic [PCW-1:0] saved_q, saved_n;
  logic           susp_q, susp_n;
  logic [CW-1:0]  slot_q;
  logic [NCTX-1:0] free_vec, sup_vec, work_vec, avail;
  logic [CW-1:0]  tgt;
  logic           have_tgt, resumed, do_spawn;

  for (genvar g = 0; g < NCTX; g++) begin : g_vec
    assign free_vec[g] = (mode_q[g] == FREE);
    assign sup_vec[g]  = (mode_q[g] == SUPV);
    assign work_vec[g] = (mode_q[g] == WORK);
  end

  assign avail         = free_vec | (work_vec & exit_i);
  assign issue_ctx     = slot_q;
  assign issue_valid   = !free_vec[slot_q];
  assign issue_sup     = sup_vec[slot_q];
  assign issue_pc      = pc_q[slot_q];
  assign sup_suspended = susp_q;
  assign do_spawn      = spawn_req && issue_sup;

  always_comb begin
    tgt = '0;
    have_tgt = 1'b0;
    for (int i = NCTX - 1; i >= 0; i--)
      if (avail[i]) begin
        tgt = CW'(i);
        have_tgt = 1'b1;
      end
  end

  always_comb begin
    for (int i = 0; i < NCTX; i++) begin
      mode_n[i] = mode_q[i];
      pc_n[i]   = pc_q[i];
    end
    saved_n = saved_q;
    susp_n  = susp_q;
    resumed = 1'b0;
    if (issue_valid) pc_n[slot_q] = pc_q[slot_q] + 1'b1;
    for (int i = 0; i < NCTX; i++)
      if (exit_i[i] && work_vec[i]) begin
        mode_n[i] = FREE;
        if (susp_q && !resumed) begin
          mode_n[i] = SUPV;
          pc_n[i]   = saved_q;
          susp_n    = 1'b0;
          resumed   = 1'b1;
        end
      end
    if (do_spawn) begin
      if (have_tgt) begin
        mode_n[tgt] = WORK;
        pc_n[tgt]   = spawn_addr;
      end else begin
        mode_n[slot_q] = WORK;
        pc_n[slot_q]   = spawn_addr;
        saved_n        = pc_q[slot_q] + 1'b1;
        susp_n         = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q  <= '0;
      susp_q  <= 1'b0;
      saved_q <= '0;
      for (int i = 0; i < NCTX; i++) begin
        mode_q[i] <= (i == 0) ? SUPV : FREE;
        pc_q[i]   <= BOOT_PC;
      end
    end else begin
      slot_q  <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
      susp_q  <= susp_n;
      saved_q <= saved_n;
      for (int i = 0; i < NCTX; i++) begin
        mode_q[i] <= mode_n[i];
        pc_q[i]   <= pc_n[i];
      end
    end
  end

  assert_one_sup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sup_vec) <= 1);

  assert_susp_no_sup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sup_suspended ? (sup_vec == '0) : ($countones(sup_vec) == 1));

  assert_rotation_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> issue_ctx == (($past(issue_ctx) == LAST) ? '0 : $past(issue_ctx) + 1'b1));

  assert_spawn_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (spawn_req && !issue_sup && exit_i == '0) |=> free_vec == $past(free_vec));

  assert_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_suspended && (exit_i & work_vec) != '0) |=> !sup_suspended);
endmodule

// File: tb/test_barrel_sched.sv
`timescale 1ns/1ps
module test_barrel_sched;
  localparam int N = 6;
  logic clk = 1'b0, rst_n = 1'b0, spawn_req = 1'b0;
  logic [15:0] spawn_addr = '0;
  logic [N-1:0] exit_i = '0;
  logic issue_valid, issue_sup, sup_suspended;
  logic [2:0] issue_ctx;
  logic [15:0] issue_pc;

  int vectors = 0, miscompares = 0, t = 0;
  int emode [N];
  logic [15:0] epc [N];
  logic [15:0] saved;

  always #4 clk = ~clk;

  barrel_sched i_barrel_sched (.clk(clk), .rst_n(rst_n), .spawn_req(spawn_req),
    .spawn_addr(spawn_addr), .exit_i(exit_i), .issue_valid(issue_valid),
    .issue_ctx(issue_ctx), .issue_pc(issue_pc), .issue_sup(issue_sup),
    .sup_suspended(sup_suspended));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at t=%0d", req, act, exp, t);
    end
  endtask

  task automatic step();
    int s;
    s = t % N;
    chk(issue_ctx == 3'(s), "R6", issue_ctx, s);
    chk(issue_valid == (emode[s] != 0), "R9", issue_valid, emode[s] != 0);
    chk(issue_sup == (emode[s] == 1), "R1", issue_sup, emode[s] == 1);
    if (emode[s] != 0) begin
      chk(issue_pc == epc[s], "R7", issue_pc, epc[s]);
      epc[s] = epc[s] + 1;
    end
    @(posedge clk);
    t++;
    @(negedge clk);
  endtask

  task automatic go(input int s);
    while (t % N != s) step();
  endtask

  initial begin
    #800000;
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      emode[i] = (i == 0) ? 1 : 0;
      epc[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(issue_ctx == 0 && issue_valid && issue_sup && issue_pc == 0, "R8",
        {issue_ctx, issue_valid, issue_sup}, 'b00011);
    chk(!sup_suspended, "R8", sup_suspended, 0);
    repeat (N) step();

    // spawn outside the supervisor turn is dropped
    go(3);
    spawn_req = 1'b1; spawn_addr = 16'h0050;
    step();
    spawn_req = 1'b0;
    go(4);
    chk(!issue_valid, "R2", issue_valid, 0);
    repeat (N) step();

    // fill every free context, lowest index first
    for (int k = 1; k < N; k++) begin
      go(0);
      spawn_req = 1'b1; spawn_addr = 16'h0100 + 16'(k * 16);
      step();
      spawn_req = 1'b0;
      emode[k] = 2; epc[k] = 16'h0100 + 16'(k * 16);
      chk(!sup_suspended, "R4", sup_suspended, 0);
      go(k);
      chk(issue_valid && !issue_sup && issue_pc == epc[k], "R3", issue_pc, epc[k]);
    end

    // no free context: supervisor lends its own
    go(0);
    saved = epc[0] + 1;
    spawn_req = 1'b1; spawn_addr = 16'h0200;
    step();
    spawn_req = 1'b0;
    emode[0] = 2; epc[0] = 16'h0200;
    chk(sup_suspended, "R4", sup_suspended, 1);
    go(0);
    chk(issue_valid && !issue_sup && issue_pc == 16'h0200, "R4", issue_pc, 16'h0200);

    // spawn while suspended is dropped
    spawn_req = 1'b1; spawn_addr = 16'h0300;
    step();
    spawn_req = 1'b0;
    chk(sup_suspended, "R2", sup_suspended, 1);
    repeat (N) step();

    // worker 3 exits: supervisor resumes there
    go(1);
    exit_i = 6'b001000;
    step();
    exit_i = '0;
    emode[3] = 1; epc[3] = saved;
    chk(!sup_suspended, "R5", sup_suspended, 0);
    go(3);
    chk(issue_sup && issue_pc == saved, "R5", issue_pc, saved);
    repeat (N) step();

    // lent context finishes its worker task
    go(2);
    exit_i = 6'b000001;
    step();
    exit_i = '0;
    emode[0] = 0;
    go(0);
    chk(!issue_valid, "R3", issue_valid, 0);

    // exits on supervisor and free contexts are ignored
    go(4);
    exit_i = 6'b001001;
    step();
    exit_i = '0;
    go(3);
    chk(issue_sup && issue_valid, "R3", issue_sup, 1);
    chk(!sup_suspended, "R3", sup_suspended, 0);

    // reuse of the freed context 0
    spawn_req = 1'b1; spawn_addr = 16'h0400;
    step();
    spawn_req = 1'b0;
    emode[0] = 2; epc[0] = 16'h0400;
    go(0);
    chk(issue_valid && issue_pc == 16'h0400, "R3", issue_pc, 16'h0400);

    // two workers exit together, then spawn picks the lower one
    go(5);
    exit_i = 6'b000110;
    step();
    exit_i = '0;
    emode[1] = 0; emode[2] = 0;
    go(3);
    spawn_req = 1'b1; spawn_addr = 16'h0500;
    step();
    spawn_req = 1'b0;
    emode[1] = 2; epc[1] = 16'h0500;
    go(2);
    chk(!issue_valid, "R9", issue_valid, 0);

    // exit and spawn in the same cycle: exiting worker 1 is reused
    go(3);
    exit_i = 6'b000010;
    spawn_req = 1'b1; spawn_addr = 16'h0600;
    step();
    exit_i = '0; spawn_req = 1'b0;
    epc[1] = 16'h0600;
    chk(!sup_suspended, "R3", sup_suspended, 0);
    repeat (3 * N) step();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule